// File: doc/BRIEF.md
# Downstream Bus Channel Selector with Serial Control Target

This block sits on an upstream two-wire serial bus (SCL/SDA) as a target device. It holds one control byte that chooses which of four downstream bus segments is connected. A controller addresses it, writes the control byte, and can read the byte back.

When the byte is read, the upper nibble carries the live interrupt status of the four downstream channels. The low three bits return the stored selection. A new selection is only a pending one until the controller ends the transfer with a STOP. At that point the registered one-hot channel-enable vector is updated. Every downstream line is therefore idle-high at the moment of connection.

SCL and SDA are oversampled on the system clock. The block never drives SDA high. Its only SDA output is an open-drain pull-down enable.

Top module: `i2c_chan_select`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) only a 7-bit address equal to binary 1110 followed by `addr_strap[2:0]`, sent MSB first. Any other address gets no acknowledge, and data following it changes nothing.
- R2: Each data byte written after an acknowledged write address is stored. When several bytes arrive in one transfer, only the last one is kept, and its bits 2:0 read back in bits 2:0.
- R3: A read returns `irq_status[3:0]` in bits 7:4 (bit 7 = channel 3), 0 in bit 3, and the stored bits 2:0 below that. Written values of bits 7:3 have no effect on the read value.
- R4: The stored byte's bit 2 is the enable and bits 1:0 are the channel index. When the enable is 1, the applied `chan_en` has exactly bit [index] set. When the enable is 0, `chan_en` is all zeros.
- R5: `chan_en` changes only after a STOP (SDA rising while SCL is high). A repeated START does not apply a pending selection.
- R6: After reset, `chan_en` is 0 and the stored control bits 2:0 read back as 0.
- R7: The block acknowledges every written data byte. On reads it releases SDA during the ninth clock. A controller NACK ends the read with SDA released, and a controller ACK makes it send the byte again.
- R8: An address byte with bit 0 = 1 starts a read transfer; bit 0 = 0 starts a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Upstream serial clock line level |
| sda_in | input | 1 | Upstream serial data line level (wired bus value) |
| sda_oe | output | 1 | When 1, the upstream data line is pulled low |
| addr_strap | input | 3 | Strapped low address bits |
| irq_status | input | 4 | Interrupt status of downstream channels 3..0 |
| chan_en | output | 4 | Registered one-hot enable of the connected channel |

## Verification
The assertions assume a well-formed upstream bus. SDA moves only while SCL is low, except at START and STOP. Each SCL phase also lasts well beyond the three-cycle synchronizer and edge-detect latency, so every edge is seen once and in order. The stimulus holds a quarter bit period of eight system clocks. It changes data only after SCL has been low for that long, and it changes strap and interrupt inputs only while the bus is idle.

// File: rtl/chmux_pkg.sv
package chmux_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_CH  = 4;
    localparam int SEL_W   = $clog2(NUM_CH);
    localparam int EN_BIT  = SEL_W;
    localparam int ADDR_W  = 7;
    localparam int STRAP_W = 3;
    localparam int FIXED_W = ADDR_W - STRAP_W;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    localparam logic [FIXED_W-1:0] ADDR_FIXED = 4'b1110;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_t;

    function automatic logic addr_hit(
        input logic [ADDR_W-1:0]  rx_addr,
        input logic [STRAP_W-1:0] strap
    );
        return rx_addr == {ADDR_FIXED, strap};
    endfunction

    function automatic logic [NUM_CH-1:0] sel_to_onehot(input ctrl_t c);
        logic [NUM_CH-1:0] v;
        v = '0;
        if (c.en) v[c.sel] = 1'b1;
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_readback(
        input logic [NUM_CH-1:0] irq,
        input ctrl_t             c
    );
        logic [BYTE_W-1:0] b;
        b = '0;
        b[BYTE_W-1 -: NUM_CH] = irq;
        b[EN_BIT]             = c.en;
        b[SEL_W-1:0]          = c.sel;
        return b;
    endfunction

endpackage

// File: rtl/chmux_line_sync.sv
module chmux_line_sync
    import chmux_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev,
    output logic    sda_q
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
            ev       <= '0;
            sda_q    <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
            sda_q    <= sda_s;
            ev.start <= scl_s & scl_prev & sda_prev & ~sda_s;
            ev.stop  <= scl_s & scl_prev & ~sda_prev & sda_s;
            ev.rise  <= scl_s & ~scl_prev;
            ev.fall  <= ~scl_s & scl_prev;
        end
    end

endmodule

// File: rtl/chmux_target_engine.sv
module chmux_target_engine
    import chmux_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic               sda_q,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_byte,
    output logic               sda_oe,
    output logic               wr_stb,
    output ctrl_t              wr_ctrl
);

    tgt_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              is_read;
    logic              nack;

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txreg   <= '0;
            is_read <= 1'b0;
            nack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_ctrl <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (ev.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_q};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (ev.fall && cnt == CNT_FULL) begin
                            if (addr_hit(shreg[BYTE_W-1:1], strap)) begin
                                sda_oe  <= 1'b1;
                                is_read <= shreg[0];
                                state   <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (is_read) begin
                                txreg  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (ev.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_q};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (ev.fall && cnt == CNT_FULL) begin
                            wr_stb  <= 1'b1;
                            wr_ctrl <= '{en: shreg[EN_BIT], sel: shreg[SEL_W-1:0]};
                            sda_oe  <= 1'b1;
                            state   <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= ST_RACK;
                            end else begin
                                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txreg[BYTE_W-2];
                                cnt    <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            nack <= sda_q;
                        end else if (ev.fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                txreg  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7: every accepted data byte is acknowledged
    assert_ack_on_write_R7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> sda_oe);

    // R7: the line is released once a START has been seen
    assert_release_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe);

    // R7: an idle target never holds the line low
    assert_idle_released_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/chmux_ctrl_reg.sv
module chmux_ctrl_reg
    import chmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  ctrl_t             wr_ctrl,
    input  logic              stop,
    output ctrl_t             pend,
    output logic [NUM_CH-1:0] chan_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            chan_en <= '0;
        end else begin
            if (wr_stb) pend <= wr_ctrl;
            if (stop) chan_en <= sel_to_onehot(pend);
        end
    end

    // R5: the active vector only moves in the cycle after a STOP
    assert_hold_until_stop_R5: assert property (@(posedge clk) disable iff (rst)
        !stop |=> $stable(chan_en));

    // R4: never more than one channel connected
    assert_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_en));

endmodule

// File: rtl/i2c_chan_select.sv
module i2c_chan_select
    import chmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [NUM_CH-1:0]  irq_status,
    output logic [NUM_CH-1:0]  chan_en
);

    bus_ev_t           ev;
    logic              sda_q;
    logic              wr_stb;
    ctrl_t             wr_ctrl;
    ctrl_t             pend;
    logic [BYTE_W-1:0] rd_byte;

    chmux_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev),
        .sda_q  (sda_q)
    );

    assign rd_byte = pack_readback(irq_status, pend);

    chmux_target_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .sda_q   (sda_q),
        .strap   (addr_strap),
        .rd_byte (rd_byte),
        .sda_oe  (sda_oe),
        .wr_stb  (wr_stb),
        .wr_ctrl (wr_ctrl)
    );

    chmux_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_ctrl (wr_ctrl),
        .stop    (ev.stop),
        .pend    (pend),
        .chan_en (chan_en)
    );

endmodule

// File: tb/i2c_chan_select_test.sv
module i2c_chan_select_test;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [2:0] strap = 3'd0;
    logic [3:0] irq = 4'd0;
    logic [3:0] chan_en;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_chan_select uut (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .addr_strap (strap),
        .irq_status (irq),
        .chan_en    (chan_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (scl_m) begin
            sda_m = 1'b0;
        end else begin
            sda_m = 1'b1;
            idle(Q);
            scl_m = 1'b1;
            idle(Q);
            sda_m = 1'b0;
        end
        idle(Q);
        scl_m = 1'b0;
        idle(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        idle(Q);
        scl_m = 1'b1;
        idle(Q);
        sda_m = 1'b1;
        idle(Q);
    endtask

    task automatic put_bit(input logic b, output logic seen);
        sda_m = b;
        idle(Q);
        scl_m = 1'b1;
        idle(Q);
        seen = sda_line;
        idle(Q);
        scl_m = 1'b0;
        idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], s);
        put_bit(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, s);
            d[i] = s;
        end
        put_bit(!give_ack, s);
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {4'b1110, strap, rw};
    endfunction

    function automatic logic [3:0] exp_onehot(input logic [7:0] v);
        return v[2] ? (4'b0001 << v[1:0]) : 4'b0000;
    endfunction

    task automatic read_ctrl(output logic [7:0] d, output logic acked);
        bus_start();
        send_byte(dev(1'b1), acked);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R7 actual hung expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic       ak;
        logic [7:0] rd;
        logic [7:0] rd2;
        logic [3:0] active;
        logic [7:0] cand [12];

        idle(5);
        rst = 1'b0;
        idle(4);

        // R6: reset state
        check("R6 chan_en after reset", 32'(chan_en), 32'h0);
        irq = 4'b1010;
        read_ctrl(rd, ak);
        check("R8 read address acknowledged", 32'(ak), 32'h1);
        check("R6 stored bits after reset", 32'(rd[2:0]), 32'h0);
        check("R3 readback after reset", 32'(rd), 32'hA0);

        // R1: address sweep over every strap value
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int k = 0; k < 8; k++) cand[k] = 8'(8'h70 + k);
            cand[8]  = 8'h00;
            cand[9]  = 8'h7F;
            cand[10] = {1'b0, 4'b0110, 3'(s)};
            cand[11] = {1'b0, 4'b1111, 3'(s)};
            for (int k = 0; k < 12; k++) begin
                bus_start();
                send_byte({cand[k][6:0], 1'b0}, ak);
                bus_stop();
                check("R1 address acknowledge", 32'(ak),
                      32'(cand[k][6:0] == {4'b1110, 3'(s)}));
            end
        end

        // R2 R3 R4 R5: control byte sweep
        strap = 3'd5;
        active = 4'b0000;
        for (int u = 0; u < 4; u++) begin
            for (int lo = 0; lo < 8; lo++) begin
                logic [7:0] v;
                logic [7:0] up;
                up = (u == 0) ? 8'h00 : (u == 1) ? 8'hF8 : (u == 2) ? 8'hA8 : 8'h50;
                v = up | 8'(lo);
                irq = 4'((u * 8 + lo) * 7);
                bus_start();
                send_byte(dev(1'b0), ak);
                check("R8 write address acknowledged", 32'(ak), 32'h1);
                send_byte(v, ak);
                check("R7 data byte acknowledged", 32'(ak), 32'h1);
                check("R5 unchanged before STOP", 32'(chan_en), 32'(active));
                bus_stop();
                active = exp_onehot(v);
                check("R4 channel applied after STOP", 32'(chan_en), 32'(active));
                read_ctrl(rd, ak);
                check("R3 R2 readback", 32'(rd), 32'({irq, 1'b0, v[2:0]}));
            end
        end

        // R2: several bytes in one transfer, last one wins
        irq = 4'b0000;
        bus_start();
        send_byte(dev(1'b0), ak);
        send_byte(8'h04, ak);
        check("R7 first of several acknowledged", 32'(ak), 32'h1);
        send_byte(8'h07, ak);
        send_byte(8'h05, ak);
        check("R7 last of several acknowledged", 32'(ak), 32'h1);
        check("R5 no change before STOP", 32'(chan_en), 32'(active));
        bus_stop();
        active = 4'b0010;
        check("R2 last byte applied", 32'(chan_en), 32'(active));
        read_ctrl(rd, ak);
        check("R2 last byte read back", 32'(rd), 32'h05);

        // R5: repeated START does not apply the pending selection
        bus_start();
        send_byte(dev(1'b0), ak);
        send_byte(8'h07, ak);
        bus_start();
        send_byte(dev(1'b1), ak);
        check("R8 read after repeated START acknowledged", 32'(ak), 32'h1);
        recv_byte(1'b0, rd);
        check("R2 pending value read back", 32'(rd), 32'h07);
        check("R5 repeated START keeps old channel", 32'(chan_en), 32'(active));
        bus_stop();
        active = 4'b1000;
        check("R5 STOP applies pending channel", 32'(chan_en), 32'(active));

        // R7: multi-byte read with controller ACK then NACK
        irq = 4'b0110;
        bus_start();
        send_byte(dev(1'b1), ak);
        recv_byte(1'b1, rd);
        recv_byte(1'b0, rd2);
        check("R7 first read byte", 32'(rd), 32'h67);
        check("R7 byte resent after ACK", 32'(rd2), 32'h67);
        check("R7 line released after NACK", 32'(sda_oe), 32'h0);
        bus_stop();

        // R1: data after a foreign address has no effect
        bus_start();
        send_byte({4'b1110, 3'd2, 1'b0}, ak);
        check("R1 foreign address not acknowledged", 32'(ak), 32'h0);
        send_byte(8'h04, ak);
        bus_stop();
        check("R1 channel kept after foreign write", 32'(chan_en), 32'(active));
        read_ctrl(rd, ak);
        check("R1 stored byte kept after foreign write", 32'(rd[2:0]), 32'h7);

        // R4 R3: disable with upper bits set
        bus_start();
        send_byte(dev(1'b0), ak);
        send_byte(8'hF8, ak);
        bus_stop();
        check("R4 disabled means no channel", 32'(chan_en), 32'h0);
        read_ctrl(rd, ak);
        check("R3 upper written bits ignored", 32'(rd), 32'h60);

        done = 1;
        report();
        $finish;
    end

endmodule